// File: doc/BRIEF.md
# Multi-Width Atomic Counter File

This block holds a byte-addressed array of counters, 2048 bytes by default. Any naturally aligned group of 1, 2, 4 or 8 bytes can be used as one counter. Every operation is a single-cycle read-modify-write, so an update can never be lost between its read and its write.

A load request performs a complete fetch-and-add by itself. It carries a signed 22-bit increment inside its request word, returns the counter value from before the update, and leaves the sum in the counter. A store request carries a data word, and one flag bit in its request word chooses the action. The data is either added to the counter or written over it. A store returns no data.

Bytes are big-endian within each aligned 8-byte group. A request whose index is not a multiple of its operand size is answered with an error and changes nothing.

Top module: `atomic_counter_file`

## Requirements
- R1: After the synchronous active-high reset, every counter reads zero and `rsp_valid`, `rsp_err` and `rsp_data` are all zero.
- R2: The request word fields are decoded only from these positions: counter byte index in bits 10:0, operand size in bits 12:11 (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes), action flag in bit 13, load increment in bits 35:14. Bits 63:36 are ignored.
- R3: A load returns the prior counter value, zero-extended, in `rsp_data`. The counter then holds the prior value plus the 22-bit increment sign-extended to the operand width, wrapped modulo 2^width with no overflow indication.
- R4: A store with bit 13 = 0 adds the low operand-width bits of `req_data` to the counter, wrapping modulo 2^width.
- R5: A store with bit 13 = 1 replaces the counter with the low operand-width bits of `req_data`.
- R6: A store is answered with `rsp_valid` = 1, `rsp_err` = 0 and `rsp_data` = 0.
- R7: A request of size 2, 4 or 8 bytes whose index is not a multiple of that size sets `rsp_err`, returns zero data and modifies no counter. A 1-byte request is never misaligned.
- R8: Within each aligned 8-byte group, the byte at the lowest index is the most significant byte of the 64-bit counter. Example: after the 64-bit value 0x0102030405060708 is written at index 64, the byte at 64 reads 0x01, the 16-bit counter at 70 reads 0x0708 and the 32-bit counter at 68 reads 0x05060708.
- R9: Every request accepted in a cycle is answered in the next cycle, and no response appears without a request. Requests issued on consecutive cycles to the same counter each see the result of the one before.
- R10: On a load, bit 13 has no effect; the operation is still a fetch-and-add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is presented this cycle |
| req_is_load | input | 1 | 1 = load (fetch-and-add), 0 = store |
| req_word | input | 64 | Request word carrying index, size, flag and increment |
| req_data | input | 64 | Store data; operand in the low bits |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request was misaligned and had no effect |
| rsp_data | output | 64 | Prior counter value for loads, zero otherwise |

## Verification
A wrong internal state corrupts the array: a wrong lane shift, mask or sign extension. It stays hidden until that counter is read again. A corrupted byte then shows up as a wrong prior value on the first later load that covers it, one cycle after that load. For this reason, every size is swept over the whole array with random values, and each store sweep is followed by a fetch-add sweep checked against a byte-level model. Writes into the wrong lane or the wrong word are then caught when a later load of a different width reads the neighbouring counters.

// File: rtl/acf_pkg.sv
`timescale 1ns/1ps
package acf_pkg;
    localparam int WORD_W     = 64;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int OFF_W      = $clog2(WORD_BYTES);
    localparam int SH_W       = $clog2(WORD_W);
    localparam int REQ_W      = 64;

    // request word layout
    localparam int IDX_LSB  = 0;
    localparam int IDX_W    = 11;
    localparam int SIZE_LSB = 11;
    localparam int FLAG_BIT = 13;
    localparam int INC_LSB  = 14;
    localparam int INC_W    = 22;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } acf_size_e;

    typedef enum logic [1:0] {
        OP_FETCH_ADD = 2'd0,
        OP_STORE_ADD = 2'd1,
        OP_STORE_SET = 2'd2
    } acf_op_e;

    typedef struct packed {
        acf_op_e           op;
        acf_size_e         size;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] operand;
        logic              misaligned;
    } acf_req_t;

    // ones in the low 8 << size bits
    function automatic logic [WORD_W-1:0] field_mask(acf_size_e sz);
        logic [WORD_W-1:0] m;
        m = '1;
        m = m >> (WORD_W - (8 << int'(sz)));
        return m;
    endfunction

    // index bits that must be zero for a naturally aligned access
    function automatic logic [OFF_W-1:0] align_bits(acf_size_e sz);
        return OFF_W'((1 << int'(sz)) - 1);
    endfunction

    // big-endian: the lowest byte offset is the most significant lane
    function automatic logic [SH_W-1:0] lane_shift(logic [OFF_W-1:0] off, acf_size_e sz);
        int s;
        s = 8 * (WORD_BYTES - int'(off) - (1 << int'(sz)));
        return SH_W'(s);
    endfunction
endpackage

// File: rtl/acf_decode.sv
`timescale 1ns/1ps
module acf_decode
    import acf_pkg::*;
(
    input  logic              is_load,
    input  logic [REQ_W-1:0]  word,
    input  logic [WORD_W-1:0] data,
    output acf_req_t          req
);
    logic [INC_W-1:0] inc;

    always_comb begin
        inc      = word[INC_LSB +: INC_W];
        req.size = acf_size_e'(word[SIZE_LSB +: 2]);
        req.idx  = word[IDX_LSB +: IDX_W];
        if (is_load) begin
            req.op      = OP_FETCH_ADD;
            req.operand = {{(WORD_W-INC_W){inc[INC_W-1]}}, inc};
        end else if (word[FLAG_BIT]) begin
            req.op      = OP_STORE_SET;
            req.operand = data;
        end else begin
            req.op      = OP_STORE_ADD;
            req.operand = data;
        end
        req.misaligned = |(req.idx[OFF_W-1:0] & align_bits(req.size));
    end
endmodule

// File: rtl/acf_lane_alu.sv
`timescale 1ns/1ps
module acf_lane_alu
    import acf_pkg::*;
(
    input  logic [WORD_W-1:0] old_word,
    input  acf_req_t          req,
    output logic [WORD_W-1:0] old_field,
    output logic [WORD_W-1:0] new_word
);
    logic [SH_W-1:0]   sh;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] sum;

    always_comb begin
        mask      = field_mask(req.size);
        sh        = lane_shift(req.idx[OFF_W-1:0], req.size);
        old_field = (old_word >> sh) & mask;
        sum       = (req.op == OP_STORE_SET) ? req.operand : old_field + req.operand;
        new_word  = (old_word & ~(mask << sh)) | ((sum & mask) << sh);
    end
endmodule

// File: rtl/atomic_counter_file.sv
`timescale 1ns/1ps
module atomic_counter_file
    import acf_pkg::*;
#(
    parameter int NUM_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_is_load,
    input  logic [REQ_W-1:0]  req_word,
    input  logic [WORD_W-1:0] req_data,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_data
);
    localparam int NUM_WORDS = NUM_BYTES / WORD_BYTES;
    localparam int WADDR_W   = $clog2(NUM_WORDS);

    acf_req_t          dec;
    logic [WORD_W-1:0] mem [NUM_WORDS];
    logic [WADDR_W-1:0] waddr;
    logic [WORD_W-1:0] old_word;
    logic [WORD_W-1:0] old_field;
    logic [WORD_W-1:0] new_word;

    acf_decode u_decode (
        .is_load (req_is_load),
        .word    (req_word),
        .data    (req_data),
        .req     (dec)
    );

    assign waddr    = dec.idx[OFF_W +: WADDR_W];
    assign old_word = mem[waddr];

    acf_lane_alu u_alu (
        .old_word  (old_word),
        .req       (dec),
        .old_field (old_field),
        .new_word  (new_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                mem[i] <= '0;
            end
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && dec.misaligned;
            rsp_data  <= '0;
            if (req_valid && !dec.misaligned) begin
                mem[waddr] <= new_word;
                if (dec.op == OP_FETCH_ADD) begin
                    rsp_data <= old_field;
                end
            end
        end
    end
endmodule

// File: rtl/acf_checker.sv
`timescale 1ns/1ps
module acf_checker
    import acf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_is_load,
    input logic [REQ_W-1:0]  req_word,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [WORD_W-1:0] rsp_data
);
    logic [1:0] sz;
    assign sz = req_word[SIZE_LSB +: 2];

    AST_RSP_EVERY_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);  // R9
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_err && rsp_data == '0));  // R9
    AST_STORE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_is_load) |=> rsp_data == '0);  // R6
    AST_ODD_WIDE_ERR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_word[IDX_LSB] && sz != 2'd0) |=> rsp_err);  // R7
    AST_BYTE_NEVER_ERR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && sz == 2'd0) |=> !rsp_err);  // R7
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_data == '0));  // R7
    AST_NARROW_RESULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_load && sz == 2'd0) |=> rsp_data[WORD_W-1:8] == '0);  // R3
endmodule

bind atomic_counter_file acf_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_is_load (req_is_load),
    .req_word    (req_word),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_data    (rsp_data)
);

// File: tb/atomic_counter_file_tb.sv
`timescale 1ns/1ps
module atomic_counter_file_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_is_load;
    logic [63:0] req_word;
    logic [63:0] req_data;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_data;

    always #2.5 clk = ~clk;

    atomic_counter_file u_dut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_is_load (req_is_load),
        .req_word    (req_word),
        .req_data    (req_data),
        .rsp_valid   (rsp_valid),
        .rsp_err     (rsp_err),
        .rsp_data    (rsp_data)
    );

    logic [7:0]  model [2048];
    logic [63:0] rs = 64'h9E3779B97F4A7C15;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    function automatic logic [63:0] xs(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    function automatic logic [63:0] msk(input int len);
        if (len == 8) return '1;
        return (64'd1 << (8 * len)) - 64'd1;
    endfunction

    function automatic logic [63:0] mread(input int idx, input int len);
        logic [63:0] v = '0;
        for (int k = 0; k < len; k++) v = (v << 8) | 64'(model[idx + k]);
        return v;
    endfunction

    task automatic mwrite(input int idx, input int len, input logic [63:0] v);
        for (int k = 0; k < len; k++) model[idx + k] = v[8*(len-1-k) +: 8];
    endtask

    function automatic logic [63:0] mk(input int idx, input int sz, input bit flag,
                                       input logic [21:0] inc, input logic [27:0] junk);
        return {junk, inc, flag, 2'(sz), 11'(idx)};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [65:0] act, input logic [65:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input bit is_load, input logic [63:0] word, input logic [63:0] data,
                         output logic [65:0] r);
        req_valid   = 1'b1;
        req_is_load = is_load;
        req_word    = word;
        req_data    = data;
        @(posedge clk);
        #1;
        r = {rsp_valid, rsp_err, rsp_data};
    endtask

    task automatic fetch_add(input string tag, input int idx, input int sz,
                             input logic [21:0] inc, input bit flag, input logic [27:0] junk);
        int len = 1 << sz;
        logic [63:0] old, nv;
        logic [65:0] r;
        old = mread(idx, len);
        nv  = (old + {{42{inc[21]}}, inc}) & msk(len);
        issue(1'b1, mk(idx, sz, flag, inc, junk), rs, r);
        chk(tag, $sformatf("load idx %0d size %0d", idx, sz), r, {2'b10, old});
        mwrite(idx, len, nv);
    endtask

    task automatic store(input string tag, input int idx, input int sz,
                         input bit set, input logic [63:0] data);
        int len = 1 << sz;
        logic [63:0] old, nv;
        logic [65:0] r;
        old = mread(idx, len);
        nv  = set ? (data & msk(len)) : ((old + data) & msk(len));
        issue(1'b0, mk(idx, sz, set, 22'(rs), 28'h0), data, r);
        chk(tag, $sformatf("store idx %0d size %0d", idx, sz), r, {2'b10, 64'h0});
        mwrite(idx, len, nv);
    endtask

    initial begin
        logic [65:0] r;
        rst = 1'b1; req_valid = 1'b0; req_is_load = 1'b0; req_word = '0; req_data = '0;
        for (int i = 0; i < 2048; i++) model[i] = 8'h00;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        chk("R1", "idle outputs after reset", {rsp_valid, rsp_err, rsp_data}, 66'h0);

        // R1: every counter is zero after reset
        for (int w = 0; w < 256; w++) fetch_add("R1", w * 8, 3, 22'h0, 1'b0, 28'h0);

        // R8: fixed big-endian layout example
        store("R8", 64, 3, 1'b1, 64'h0102030405060708);
        issue(1'b1, mk(64, 0, 1'b0, 22'h0, 28'h0), '0, r);
        chk("R8", "byte at 64", r, {2'b10, 64'h01});
        issue(1'b1, mk(70, 1, 1'b0, 22'h0, 28'h0), '0, r);
        chk("R8", "half at 70", r, {2'b10, 64'h0708});
        issue(1'b1, mk(68, 2, 1'b0, 22'h0, 28'h0), '0, r);
        chk("R8", "word at 68", r, {2'b10, 64'h05060708});

        // sweeps over every size and every aligned index
        for (int sz = 0; sz < 4; sz++) begin
            for (int idx = 0; idx < 2048; idx += (1 << sz)) begin
                rs = xs(rs);
                store("R5", idx, sz, 1'b1, rs);
            end
            for (int idx = 0; idx < 2048; idx += (1 << sz)) begin
                rs = xs(rs);
                fetch_add("R3", idx, sz, rs[21:0], 1'b0, 28'h0);
            end
            for (int idx = 0; idx < 2048; idx += (1 << sz)) begin
                rs = xs(rs);
                store("R4", idx, sz, 1'b0, rs);
            end
        end
        // R8: cross-width reads of what the 64-bit sweep left behind
        for (int idx = 0; idx < 64; idx++) fetch_add("R8", idx, 0, 22'h0, 1'b0, 28'h0);

        // R3 wrap corners
        store("R3", 0, 3, 1'b1, 64'd5);
        fetch_add("R3", 0, 3, 22'h200000, 1'b0, 28'h0);
        fetch_add("R3", 0, 3, 22'h0, 1'b0, 28'h0);
        store("R3", 9, 0, 1'b1, 64'hFF);
        fetch_add("R3", 9, 0, 22'h1, 1'b0, 28'h0);
        fetch_add("R3", 9, 0, 22'h3FFFFF, 1'b0, 28'h0);
        fetch_add("R3", 16, 2, 22'h1FFFFF, 1'b0, 28'h0);
        // R4 wrap at 16 bits with high data bits set
        store("R4", 20, 1, 1'b1, 64'hFFFF);
        store("R4", 20, 1, 1'b0, 64'hABCD_0000_0000_0002);
        fetch_add("R4", 20, 1, 22'h0, 1'b0, 28'h0);

        // R2: bits above the increment field are ignored
        fetch_add("R2", 128, 2, 22'h00123, 1'b0, 28'hFFFFFFF);
        fetch_add("R2", 128, 2, 22'h0, 1'b0, 28'hA5A5A5A);
        // R10: flag bit on a load is still fetch-and-add
        fetch_add("R10", 136, 3, 22'h00077, 1'b1, 28'h0);
        fetch_add("R10", 136, 3, 22'h0, 1'b0, 28'h0);
        // R6: stores carry no data back
        store("R6", 144, 3, 1'b1, 64'hDEADBEEFCAFEF00D);
        store("R6", 144, 3, 1'b0, 64'h1);

        // R7: misaligned requests flag an error and change nothing
        store("R7", 200, 3, 1'b1, 64'h1122334455667788);
        for (int sz = 1; sz < 4; sz++) begin
            for (int off = 1; off < 8; off++) begin
                if ((off & ((1 << sz) - 1)) != 0) begin
                    issue(1'b1, mk(200 + off, sz, 1'b0, 22'h5, 28'h0), '0, r);
                    chk("R7", $sformatf("misaligned load off %0d size %0d", off, sz), r, {2'b11, 64'h0});
                    issue(1'b0, mk(200 + off, sz, 1'b1, 22'h0, 28'h0), 64'hFFFF_FFFF_FFFF_FFFF, r);
                    chk("R7", $sformatf("misaligned store off %0d size %0d", off, sz), r, {2'b11, 64'h0});
                end
            end
        end
        fetch_add("R7", 200, 3, 22'h0, 1'b0, 28'h0);

        // R9: back-to-back updates of one counter, then an idle cycle
        store("R9", 300, 2, 1'b1, 64'd10);
        for (int k = 0; k < 4; k++) fetch_add("R9", 300, 2, 22'h3, 1'b0, 28'h0);
        store("R9", 300, 2, 1'b0, 64'd100);
        fetch_add("R9", 300, 2, 22'h0, 1'b0, 28'h0);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R9", "no response without request", {rsp_valid, rsp_err, rsp_data}, 66'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule